// File: doc/BRIEF.md
# Host Mailbox Port with Deferred Acknowledge

This block is a mailbox between an external host and a processor core. The host writes a small set of data registers and a control/status register through a single-cycle write strobe, and it gets back a one-cycle acknowledge. The processor side reads those registers and sees one interrupt line per register. The interrupt is raised while the register holds data that the processor has not yet read.

A control bit picks how an unread register is treated. With overwrite enabled, a new host write replaces the unread data and is acknowledged at once. With overwrite disabled, the write is parked in a single pending slot and its acknowledge is withheld. The parked data lands, and the acknowledge is sent, only when the processor reads the occupied register.

The processor side may be asleep. While it sleeps, host writes still land, the interrupt flags stay latched but are hidden, and processor reads have no effect. A host that waits for a withheld acknowledge therefore stalls until the processor wakes. A host-writable bit raises a fixed-length core reset pulse that also clears the mailbox. Two mode inputs control the host side. One selects a multiplexed bus, where the address is captured from the data lines. The other inverts the polarity of the acknowledge.

Top module: `host_mailbox`

## Requirements
- R1: After reset, all interrupt bits are 0, coreReset is 0, the acknowledge is at its inactive level, and the overwrite bit is 0.
- R2: A host write to a data register (addresses 0..NUM_REGS-1) that holds no unread data stores the value and marks it unread. The acknowledge is active for exactly the one cycle after the write strobe.
- R3: A processor read (procRd while procSleep is 0) presents the addressed value on procRdData in the following cycle. It clears that register's unread flag at the same edge. While awake, procIrq bit i equals register i's unread flag.
- R4: With overwrite disabled (status bit 7 = 0), a host write to an unread register is held pending and no acknowledge is given. At the edge where the processor reads that register, the read returns the old value, the pending value is stored and stays marked unread, and the acknowledge is active in the next cycle.
- R5: The host sets overwrite by writing the status register (address NUM_REGS) with bit 7 = 1. With overwrite on, a write to an unread register replaces its data and is acknowledged in the next cycle.
- R6: While a write is pending, every further host write is ignored. It gets no acknowledge and changes no register.
- R7: While procSleep is 1, procIrq is all zero and processor reads change neither procRdData nor any unread flag. Host writes still land, and the latched flags reappear on procIrq when procSleep returns to 0.
- R8: A host status write with bit 6 = 1 is acknowledged and drives coreReset high for exactly RST_CYCLES (5) cycles, starting in the next cycle. This pulse clears all unread flags, the pending write and the overwrite bit. Host writes during the pulse are ignored.
- R9: When hostMode bit 0 is 1, a hostAle strobe captures the low address bits from hostData. Later writes use that captured address, and hostAddr is ignored.
- R10: When hostMode bit 1 is 1, the acknowledge is active-low: it idles at 1 and pulses to 0.
- R11: A processor read of address NUM_REGS returns the overwrite bit in bit 7 and the unread flags in bits NUM_REGS-1:0, with all other bits 0. This read clears no flag.
- R12: A host write to an address above NUM_REGS is ignored and gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostMode | input | 2 | Bit 0: multiplexed address/data bus; bit 1: active-low acknowledge |
| hostAle | input | 1 | Address capture strobe (multiplexed mode) |
| hostWr | input | 1 | Single-cycle host write strobe |
| hostAddr | input | ADDR_W | Host register address (non-multiplexed mode) |
| hostData | input | DATA_W | Host write data; also carries the address in multiplexed mode |
| hostAck | output | 1 | Host write acknowledge |
| procSleep | input | 1 | Processor side is asleep |
| procRd | input | 1 | Processor read strobe |
| procAddr | input | ADDR_W | Processor read address |
| procRdData | output | DATA_W | Registered processor read data |
| procIrq | output | NUM_REGS | Per-register unread-data interrupt |
| coreReset | output | 1 | Core reset pulse requested by the host |

## Verification
Embedded assertions check four rules on every cycle:
- no acknowledge appears while a write is pending, or after the first cycle of a core reset pulse;
- a pending write always targets a register that is still unread;
- a reset pulse leaves every unread flag cleared;
- a committed pending write leaves its register marked unread.

Other behaviour can only be shown by the bench's scenarios, checked against a behavioural model on every clock. These include the withheld acknowledge being released by a read, the ignored writes during a pending write or a reset pulse, the hidden interrupts and dropped reads during sleep, the captured address in multiplexed mode, and the exact length of the reset pulse.

// File: rtl/host_mailbox_pkg.sv
package host_mailbox_pkg;

  localparam int OVW_BIT  = 7;
  localparam int SRST_BIT = 6;

  typedef struct packed {
    logic loadDirect;
    logic loadPend;
    logic capturePend;
    logic clearAll;
    logic readEn;
    logic ovwBit;
  } mbox_strobe_t;

endpackage

// File: rtl/host_mailbox_ctrl.sv
module host_mailbox_ctrl
  import host_mailbox_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int ADDR_W     = 3,
  parameter int RST_CYCLES = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostMode,
  input  logic                hostAle,
  input  logic                hostWr,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [ADDR_W-1:0]   hostDataAddr,
  input  logic                hostOvwBit,
  input  logic                hostSrstBit,
  input  logic                procSleep,
  input  logic                procRd,
  input  logic [ADDR_W-1:0]   procAddr,
  input  logic [NUM_REGS-1:0] validQ,
  output mbox_strobe_t        strb,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [ADDR_W-1:0]   pendAddr,
  output logic [ADDR_W-1:0]   readAddr,
  output logic                hostAck,
  output logic                coreReset
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [ADDR_W-1:0]   latAddr;
  logic [ADDR_W-1:0]   pendAddrQ;
  logic [ADDR_W-1:0]   effAddr;
  logic [CNT_W-1:0]    cntQ;
  logic                ovwQ, pendQ, ackQ;
  logic                inRst, readLive, hostGo;
  logic                isStatus, isData;
  logic                freeSel, pendFree, pendSlotValid;
  logic                accDirect, accPend, stWr, commit;
  logic [NUM_REGS-1:0] freeVec;

  assign effAddr  = hostMode[0] ? latAddr : hostAddr;
  assign inRst    = (cntQ != '0);
  assign readLive = procRd && !procSleep;

  always_comb begin
    freeSel       = 1'b0;
    pendFree      = 1'b0;
    pendSlotValid = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      freeVec[i] = !validQ[i] || (readLive && procAddr == ADDR_W'(i));
      if (effAddr == ADDR_W'(i)) freeSel = freeVec[i];
      if (pendAddrQ == ADDR_W'(i)) begin
        pendFree      = freeVec[i];
        pendSlotValid = validQ[i];
      end
    end
  end

  assign isStatus  = (effAddr == ADDR_W'(NUM_REGS));
  assign isData    = (effAddr < ADDR_W'(NUM_REGS));
  assign hostGo    = hostWr && !pendQ && !inRst;
  assign commit    = pendQ && !inRst && pendFree;
  assign accDirect = hostGo && isData && (ovwQ || freeSel);
  assign accPend   = hostGo && isData && !ovwQ && !freeSel;
  assign stWr      = hostGo && isStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr   <= '0;
      pendAddrQ <= '0;
      cntQ      <= '0;
      ovwQ      <= 1'b0;
      pendQ     <= 1'b0;
      ackQ      <= 1'b0;
    end else begin
      ackQ <= accDirect || stWr || commit;
      if (hostMode[0] && hostAle) latAddr <= hostDataAddr;
      if (inRst) begin
        cntQ  <= cntQ - CNT_W'(1);
        ovwQ  <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        if (stWr) begin
          ovwQ <= hostOvwBit;
          if (hostSrstBit) cntQ <= CNT_W'(RST_CYCLES);
        end
        if (accPend) begin
          pendQ     <= 1'b1;
          pendAddrQ <= effAddr;
        end else if (commit) begin
          pendQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strb.loadDirect  = accDirect;
    strb.loadPend    = commit;
    strb.capturePend = accPend;
    strb.clearAll    = inRst;
    strb.readEn      = readLive;
    strb.ovwBit      = ovwQ;
  end

  assign wrAddr    = effAddr;
  assign pendAddr  = pendAddrQ;
  assign readAddr  = procAddr;
  assign hostAck   = ackQ ^ hostMode[1];
  assign coreReset = inRst;

  // R6: a parked write keeps the acknowledge withheld
  assert_no_ack_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> !ackQ);

  // R8: only the status write that starts the pulse may be acknowledged
  assert_no_ack_in_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inRst && cntQ != CNT_W'(RST_CYCLES)) |-> !ackQ);

  // R4: a pending write always waits on an occupied register
  assert_pending_occupied_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> pendSlotValid);

endmodule

// File: rtl/host_mailbox_dp.sv
module host_mailbox_dp
  import host_mailbox_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  mbox_strobe_t        strb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [ADDR_W-1:0]   pendAddr,
  input  logic [ADDR_W-1:0]   readAddr,
  input  logic [DATA_W-1:0]   hostData,
  input  logic                procSleep,
  output logic [NUM_REGS-1:0] validQ,
  output logic [DATA_W-1:0]   procRdData,
  output logic [NUM_REGS-1:0] procIrq
);

  logic [DATA_W-1:0]   dataQ [NUM_REGS];
  logic [DATA_W-1:0]   pendData;
  logic [DATA_W-1:0]   statusWord;
  logic [DATA_W-1:0]   rdNext;
  logic [NUM_REGS-1:0] wrMask, pendMask, rdMask;

  always_comb begin
    statusWord                = '0;
    statusWord[OVW_BIT]       = strb.ovwBit;
    statusWord[NUM_REGS-1:0]  = validQ;
    rdNext = (readAddr == ADDR_W'(NUM_REGS)) ? statusWord : '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      wrMask[i]   = (wrAddr == ADDR_W'(i));
      pendMask[i] = (pendAddr == ADDR_W'(i));
      rdMask[i]   = (readAddr == ADDR_W'(i));
      if (rdMask[i]) rdNext = dataQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendData   <= '0;
      procRdData <= '0;
      validQ     <= '0;
      for (int i = 0; i < NUM_REGS; i++) dataQ[i] <= '0;
    end else begin
      if (strb.capturePend) pendData <= hostData;
      if (strb.readEn) procRdData <= rdNext;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strb.clearAll) begin
          dataQ[i]  <= '0;
          validQ[i] <= 1'b0;
        end else if (strb.loadDirect && wrMask[i]) begin
          dataQ[i]  <= hostData;
          validQ[i] <= 1'b1;
        end else if (strb.loadPend && pendMask[i]) begin
          dataQ[i]  <= pendData;
          validQ[i] <= 1'b1;
        end else if (strb.readEn && rdMask[i]) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  assign procIrq = procSleep ? '0 : validQ;

  // R8: the reset pulse leaves no register marked unread
  assert_cleared_after_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearAll) |-> (validQ == '0));

  // R4: a committed pending value stays unread
  assert_commit_marks_unread_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadPend && !strb.clearAll) |-> ((validQ & $past(pendMask)) == $past(pendMask)));

endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import host_mailbox_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int DATA_W     = 8,
  parameter int RST_CYCLES = 5,
  localparam int ADDR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostMode,
  input  logic                hostAle,
  input  logic                hostWr,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostData,
  output logic                hostAck,
  input  logic                procSleep,
  input  logic                procRd,
  input  logic [ADDR_W-1:0]   procAddr,
  output logic [DATA_W-1:0]   procRdData,
  output logic [NUM_REGS-1:0] procIrq,
  output logic                coreReset
);

  mbox_strobe_t        strb;
  logic [ADDR_W-1:0]   wrAddr, pendAddr, readAddr;
  logic [NUM_REGS-1:0] validQ;

  host_mailbox_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .hostAle(hostAle), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostDataAddr(hostData[ADDR_W-1:0]),
    .hostOvwBit(hostData[OVW_BIT]), .hostSrstBit(hostData[SRST_BIT]),
    .procSleep(procSleep), .procRd(procRd), .procAddr(procAddr), .validQ(validQ),
    .strb(strb), .wrAddr(wrAddr), .pendAddr(pendAddr), .readAddr(readAddr),
    .hostAck(hostAck), .coreReset(coreReset)
  );

  host_mailbox_dp #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .pendAddr(pendAddr),
    .readAddr(readAddr), .hostData(hostData), .procSleep(procSleep),
    .validQ(validQ), .procRdData(procRdData), .procIrq(procIrq)
  );

endmodule

// File: tb/test_host_mailbox.sv
`timescale 1ns/1ps
module test_host_mailbox;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] hostMode = 2'b00;
  logic       hostAle = 1'b0, hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic       hostAck;
  logic       procSleep = 1'b0, procRd = 1'b0;
  logic [2:0] procAddr = '0;
  logic [7:0] procRdData;
  logic [3:0] procIrq;
  logic       coreReset;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  host_mailbox i_host_mailbox (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .hostAle(hostAle), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostData(hostData), .hostAck(hostAck),
    .procSleep(procSleep), .procRd(procRd), .procAddr(procAddr),
    .procRdData(procRdData), .procIrq(procIrq), .coreReset(coreReset)
  );

  // behavioural reference model
  logic [7:0] mData [4];
  logic [3:0] mValid = '0;
  logic       mPend = 0, mOvw = 0, mAck = 0;
  int         mPa = 0, mCnt = 0, mLat = 0;
  logic [7:0] mPd = '0, mRd = '0;

  initial for (int i = 0; i < 4; i++) mData[i] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mData[i] = '0;
      mValid = '0; mPend = 0; mOvw = 0; mAck = 0; mPa = 0; mCnt = 0; mLat = 0;
      mPd = '0; mRd = '0;
    end else begin
      int   ea;
      logic rl, ackN;
      logic [3:0] free;
      ea = hostMode[0] ? mLat : int'(hostAddr);
      rl = procRd && !procSleep;
      ackN = 0;
      if (rl) begin
        if (procAddr < 4) mRd = mData[procAddr];
        else if (procAddr == 4) mRd = {mOvw, 3'b000, mValid};
        else mRd = '0;
      end
      for (int i = 0; i < 4; i++) free[i] = !mValid[i] || (rl && procAddr == i);
      if (rl && procAddr < 4) mValid[procAddr] = 0;
      if (mCnt != 0) begin
        mCnt = mCnt - 1;
        for (int i = 0; i < 4; i++) mData[i] = '0;
        mValid = '0; mOvw = 0; mPend = 0;
      end else if (mPend) begin
        if (free[mPa]) begin
          mData[mPa] = mPd; mValid[mPa] = 1; mPend = 0; ackN = 1;
        end
      end else if (hostWr) begin
        if (ea == 4) begin
          mOvw = hostData[7];
          if (hostData[6]) mCnt = 5;
          ackN = 1;
        end else if (ea < 4) begin
          if (mOvw || free[ea]) begin
            mData[ea] = hostData; mValid[ea] = 1; ackN = 1;
          end else begin
            mPend = 1; mPa = ea; mPd = hostData;
          end
        end
      end
      mAck = ackN;
      if (hostMode[0] && hostAle) mLat = int'(hostData[2:0]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      chk("R2 R4 R5 R10 hostAck", 32'(hostAck), 32'(mAck ^ hostMode[1]));
      chk("R3 R7 procIrq", 32'(procIrq), 32'(procSleep ? 4'b0 : mValid));
      chk("R3 R11 procRdData", 32'(procRdData), 32'(mRd));
      chk("R8 coreReset", 32'(coreReset), 32'(mCnt != 0));
    end
  end

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostWr = 1; hostAddr = a; hostData = d;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic procRead(input logic [2:0] a);
    @(negedge clk); procRd = 1; procAddr = a;
    @(negedge clk); procRd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total + 1);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    #1;
    chk("R1 reset ack", 32'(hostAck), 0);
    chk("R1 reset irq", 32'(procIrq), 0);
    chk("R1 reset coreReset", 32'(coreReset), 0);

    // R2 / R3 basic write and read
    hostWrite(3'd0, 8'hA5); #1;
    chk("R2 immediate ack", 32'(hostAck), 1);
    idle(1); #1;
    chk("R2 ack one cycle", 32'(hostAck), 0);
    chk("R2 irq set", 32'(procIrq), 32'h1);
    procRead(3'd0); #1;
    chk("R3 read data", 32'(procRdData), 32'hA5);
    chk("R3 flag cleared", 32'(procIrq), 0);

    // R4 / R6 deferred acknowledge
    hostWrite(3'd1, 8'h11);
    hostWrite(3'd1, 8'h22); #1;
    chk("R4 ack withheld", 32'(hostAck), 0);
    hostWrite(3'd2, 8'h33); #1;
    chk("R6 ignored write no ack", 32'(hostAck), 0);
    idle(2); #1;
    chk("R6 ignored write no flag", 32'(procIrq), 32'h2);
    procRead(3'd1); #1;
    chk("R4 old value read", 32'(procRdData), 32'h11);
    chk("R4 release ack", 32'(hostAck), 1);
    chk("R4 new value unread", 32'(procIrq), 32'h2);
    procRead(3'd1); #1;
    chk("R4 pending value landed", 32'(procRdData), 32'h22);

    // R12 out of range
    hostWrite(3'd5, 8'h44); #1;
    chk("R12 no ack", 32'(hostAck), 0);

    // R5 / R11 overwrite mode and status read
    hostWrite(3'd4, 8'h80);
    hostWrite(3'd3, 8'h31);
    hostWrite(3'd3, 8'h32); #1;
    chk("R5 overwrite ack", 32'(hostAck), 1);
    procRead(3'd4); #1;
    chk("R11 status word", 32'(procRdData), 32'h88);
    chk("R11 status read clears nothing", 32'(procIrq), 32'h8);
    procRead(3'd3); #1;
    chk("R5 replaced data", 32'(procRdData), 32'h32);

    // R7 sleep
    @(negedge clk); procSleep = 1;
    hostWrite(3'd0, 8'h5A); #1;
    chk("R7 irq hidden", 32'(procIrq), 0);
    procRead(3'd0); #1;
    chk("R7 read dropped", 32'(procRdData), 32'h32);
    @(negedge clk); procSleep = 0; #1;
    chk("R7 flag latched", 32'(procIrq), 32'h1);
    procRead(3'd0); #1;
    chk("R7 data landed", 32'(procRdData), 32'h5A);

    // R9 multiplexed address
    @(negedge clk); hostMode = 2'b01; hostAle = 1; hostData = 8'h02;
    @(negedge clk); hostAle = 0;
    hostWrite(3'd0, 8'h77);
    procRead(3'd2); #1;
    chk("R9 latched address used", 32'(procRdData), 32'h77);

    // R10 active-low acknowledge
    @(negedge clk); hostMode = 2'b10; #1;
    chk("R10 idle high", 32'(hostAck), 1);
    hostWrite(3'd1, 8'h66); #1;
    chk("R10 pulse low", 32'(hostAck), 0);
    @(negedge clk); hostMode = 2'b00;

    // R8 software reset pulse
    hostWrite(3'd4, 8'hC0);
    begin
      int n;
      n = 0;
      for (int k = 0; k < 8; k++) begin
        #1;
        if (coreReset) n++;
        @(negedge clk);
        hostWr = (k == 1); hostAddr = 3'd3; hostData = 8'h99;
      end
      hostWr = 0;
      chk("R8 pulse length", 32'(n), 5);
    end
    #1;
    chk("R8 flags cleared", 32'(procIrq), 0);
    procRead(3'd4); #1;
    chk("R8 overwrite cleared", 32'(procRdData), 0);

    idle(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule